// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM that follows the late-write convention. The block samples its control inputs on each rising clock edge. For a read, the stored word appears on the output in the cycle that follows the command. For a write, the address and lane selects arrive with the command, and the data arrives one cycle later. The external bidirectional bus is split into an input word, an output word and an output enable. A pad ring or a board-level model recombines them.

The word is 36 bits wide and is organised as four 9-bit lanes. Each lane has an active-low write select. Because the write data lags its address, the block holds the write in a pending stage and commits it when the data arrives. A read of that same address in the data cycle takes the incoming lanes through a bypass path. A sleep input overrides every other input and turns the output off at once. When the host turns the bus around from a read straight into a write, the block raises a protocol-error flag.

Top module: `lw_sram`

## Requirements
- R1: A read command (`sel_n`=0, `wr_n`=1, `sleep_i`=0) sampled at edge k makes `doe` high and puts the stored word on `dout` from edge k until edge k+1. The `lane_we_n` value is ignored during a read.
- R2: A write command (`sel_n`=0, `wr_n`=0, at least one `lane_we_n` bit low) sampled at edge k keeps `doe` low until edge k+1. Then `din` is sampled at edge k+1, and only the lanes whose select is low are updated. Lane i covers bits 9i+8 down to 9i, so select bit 0 maps to bits 8:0 and select bit 3 maps to bits 35:27.
- R3: A write command with `lane_we_n`=4'b1111 is an abort. No location changes, `doe` stays low, and `proto_err` stays low.
- R4: `sel_n`=1 is a deselect, whatever `wr_n` and `lane_we_n` are. `doe` is low in the following cycle and no location changes, even if `din` toggles.
- R5: With `sleep_i` high, `doe` goes low at once. It stays low in the cycle after an edge at which `sleep_i` was sampled high. All other inputs are ignored, and a write whose data cycle falls in sleep is dropped.
- R6: During and right after synchronous active-low reset, `doe` and `proto_err` are low.
- R7: A read at edge k+1 of the address written by a write command at edge k returns the `din` lanes selected by that write, merged with the old contents of the other lanes.
- R8: `proto_err` is high from edge k to edge k+1 exactly when edge k sampled a non-abort write and edge k-1 sampled a read. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Sleep request, overrides all other inputs |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Write strobe, low for write, high for read |
| lane_we_n | input | 4 | Active-low write select per 9-bit lane |
| addr | input | AW | Word address |
| din | input | 36 | Write data, sampled in the cycle after the write command |
| dout | output | 36 | Read data, zero while not driven |
| doe | output | 1 | Output enable for the external bus |
| proto_err | output | 1 | Read-to-write turnaround without a dead cycle |

## Verification
The array is first filled by a back-to-back write sweep over every address. A full read sweep then checks it, with a changing `lane_we_n` pattern that tests whether reads ignore the lane selects. All sixteen lane-select codes are then applied to one word, once followed by a delayed read and once by a read in the data cycle. This separates a lane-decode error from a bypass-merge error, and it separates the abort code from a real write. Deselects with the write strobe low, sleep during a pending write's data cycle, and read-to-write turnarounds with and without an abort show whether a stray commit, a missing drop or a wrong error flag is present.

// File: rtl/lw_sram_pkg.sv
// Package: shared constants, command type and lane-merge helper for the
// late-write SRAM model. Assumes a 36-bit word of four 9-bit lanes.
package lw_sram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_READ,
        CMD_WRITE,
        CMD_ABORT,
        CMD_SLEEP
    } cmd_e;

    // Replace the lanes of old_w flagged in sel with those of new_w.
    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  sel
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction
endpackage

// File: rtl/lw_sram_decode.sv
// Command decoder: turns the sampled control pins into one command code
// and an active-high lane mask. Purely combinational; sleep wins over all.
module lw_sram_decode
    import lw_sram_pkg::*;
(
    input  logic             sleep_i,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_we_n,
    output cmd_e             cmd,
    output logic [LANES-1:0] lane_en
);
    // Priority decode: sleep, deselect, read, abort, write.
    always_comb begin
        lane_en = ~lane_we_n;
        if (sleep_i)            cmd = CMD_SLEEP;
        else if (sel_n)         cmd = CMD_DESEL;
        else if (wr_n)          cmd = CMD_READ;
        else if (lane_en == '0) cmd = CMD_ABORT;
        else                    cmd = CMD_WRITE;
    end
endmodule

// File: rtl/lw_sram_wstage.sv
// Pending-write stage: captures address and lane mask of a write command,
// then commits din on the next edge unless that edge is a sleep cycle.
// Also produces the bypass lane mask for a read of the pending address.
module lw_sram_wstage
    import lw_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [LANES-1:0]  lane_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  arr_we,
    output logic [AW-1:0]     arr_waddr,
    output logic [WORD_W-1:0] arr_wdata,
    output logic [LANES-1:0]  byp_mask
);
    logic             pend_vld;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic             commit;

    // Hold the address and lanes of the most recent write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
        end else begin
            pend_vld <= (cmd == CMD_WRITE);
            if (cmd == CMD_WRITE) begin
                pend_addr <= addr;
                pend_mask <= lane_en;
            end
        end
    end

    // Commit in the data cycle unless sleep discards the bus contents.
    always_comb begin
        commit    = pend_vld && (cmd != CMD_SLEEP);
        arr_we    = commit ? pend_mask : '0;
        arr_waddr = pend_addr;
        arr_wdata = din;
        byp_mask  = (commit && (cmd == CMD_READ) && (addr == pend_addr)) ? pend_mask : '0;
    end
endmodule

// File: rtl/lw_sram_array.sv
// Storage array: one memory per 9-bit lane with its own write enable,
// asynchronous read. Not reset; contents are undefined until written.
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Update this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/lw_sram.sv
// Late-write SRAM top: decodes commands, registers read data for the next
// cycle, gates the output enable with sleep and flags read-to-write
// turnarounds. Assumes the host honours one-cycle-late write data.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [3:0]        lane_we_n,
    input  logic [AW-1:0]     addr,
    input  logic [35:0]       din,
    output logic [35:0]       dout,
    output logic              doe,
    output logic              proto_err
);
    cmd_e              cmd;
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  arr_we;
    logic [AW-1:0]     arr_waddr;
    logic [WORD_W-1:0] arr_wdata;
    logic [LANES-1:0]  byp_mask;
    logic [WORD_W-1:0] arr_rdata;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] dout_q;
    logic              doe_q;
    logic              prev_read;
    logic              err_q;

    lw_sram_decode u_dec (
        .sleep_i   (sleep_i),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .lane_we_n (lane_we_n),
        .cmd       (cmd),
        .lane_en   (lane_en)
    );

    lw_sram_wstage #(.AW(AW)) u_wst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .lane_en   (lane_en),
        .addr      (addr),
        .din       (din),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata),
        .byp_mask  (byp_mask)
    );

    lw_sram_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (addr),
        .rdata (arr_rdata)
    );

    // Read word with in-flight write lanes folded in.
    assign rd_word = lane_merge(arr_rdata, din, byp_mask);

    // Output register: capture read data and the enable for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doe_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            doe_q <= (cmd == CMD_READ);
            if (cmd == CMD_READ) dout_q <= rd_word;
        end
    end

    // Turnaround monitor: a real write right after a read is an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_read <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            prev_read <= (cmd == CMD_READ);
            err_q     <= (cmd == CMD_WRITE) && prev_read;
        end
    end

    assign doe       = doe_q && !sleep_i;
    assign dout      = doe ? dout_q : '0;
    assign proto_err = err_q;
endmodule

// File: rtl/lw_sram_chk.sv
// Checker for lw_sram: port-level timing properties, bound to every
// instance of the top module.
module lw_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          sel_n,
    input logic          wr_n,
    input logic [3:0]    lane_we_n,
    input logic [AW-1:0] addr,
    input logic          doe,
    input logic          proto_err
);
    logic is_rd, is_wr, is_ab;
    assign is_rd = !sleep_i && !sel_n && wr_n;
    assign is_wr = !sleep_i && !sel_n && !wr_n && (lane_we_n != 4'hF);
    assign is_ab = !sleep_i && !sel_n && !wr_n && (lane_we_n == 4'hF);

    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |=> (!doe && !proto_err));
    p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (doe || sleep_i));
    p_write_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> !doe);
    p_abort_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ab |=> (!doe && !proto_err));
    p_desel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && sel_n) |=> !doe);
    p_sleep_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !doe);
    p_sleep_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !doe);
    p_turn_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd ##1 is_wr |=> proto_err);
    p_turn_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr |=> !proto_err);
endmodule

bind lw_sram lw_sram_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .lane_we_n (lane_we_n),
    .addr      (addr),
    .doe       (doe),
    .proto_err (proto_err)
);

// File: tb/lw_sram_test.sv
// Bench for lw_sram: per-cycle reference model built from the requirements,
// inputs driven and outputs sampled at the falling edge.
module lw_sram_test;
    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [35:0]   din = '0;
    logic [35:0]   dout;
    logic          doe;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [35:0]   mdl [DEPTH];
    bit            m_pend = 1'b0;
    logic [AW-1:0] m_paddr = '0;
    logic [3:0]    m_pmask = '0;
    bit            m_prevrd = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lw_sram #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_n(sel_n),
        .wr_n(wr_n), .lane_we_n(lane_we_n), .addr(addr), .din(din),
        .dout(dout), .doe(doe), .proto_err(proto_err)
    );

    function automatic logic [35:0] pat(input int a, input int s);
        logic [63:0] v;
        v = 64'(a) * 64'h9E37_79B1 + 64'(s) * 64'h5_4321_0FED + 64'h1;
        return v[35:0];
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, predict, check the result.
    task automatic cyc(input bit slp, input bit sn, input bit wn, input logic [3:0] ln,
                       input int a, input logic [35:0] d, input string rtag = "");
        bit          is_rd, is_wr, byp;
        logic [35:0] exp_q;
        bit          exp_err;
        string       tag;
        sleep_i = slp; sel_n = sn; wr_n = wn; lane_we_n = ln;
        addr = AW'(a); din = d;
        is_rd = !slp && !sn && wn;
        is_wr = !slp && !sn && !wn && (ln != 4'hF);
        byp   = is_rd && m_pend && (AW'(a) == m_paddr);
        if (m_pend && !slp) begin
            for (int i = 0; i < 4; i++)
                if (m_pmask[i]) mdl[m_paddr][i*9 +: 9] = d[i*9 +: 9];
        end
        exp_q   = mdl[AW'(a)];
        exp_err = is_wr && m_prevrd;
        m_pend   = is_wr;
        m_paddr  = AW'(a);
        m_pmask  = ~ln;
        m_prevrd = is_rd;
        if (slp)               tag = "R5";
        else if (sn)           tag = "R4";
        else if (wn)           tag = byp ? "R7" : "R1";
        else if (ln == 4'hF)   tag = "R3";
        else                   tag = "R2";
        if (rtag != "" && is_rd) tag = rtag;
        @(posedge clk);
        @(negedge clk);
        check({tag, " doe"}, 36'(doe), 36'(is_rd));
        if (is_rd) check({tag, " data"}, dout, exp_q);
        check("R8 proto_err", 36'(proto_err), 36'(exp_err));
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6 doe in reset", 36'(doe), 36'(0));
        check("R6 proto_err in reset", 36'(proto_err), 36'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 doe after reset", 36'(doe), 36'(0));
        check("R6 proto_err after reset", 36'(proto_err), 36'(0));

        // R2: back-to-back full-word writes over every address.
        for (int a = 0; a < DEPTH; a++)
            cyc(0, 0, 0, 4'h0, a, (a == 0) ? 36'h0 : pat(a - 1, 0));
        cyc(0, 1, 1, 4'hF, 0, pat(DEPTH - 1, 0));

        // R1: read sweep, lane selects toggled and ignored.
        for (int a = 0; a < DEPTH; a++)
            cyc(0, 0, 1, 4'(a), a, 36'h0);

        // R2/R3: every lane-select code on one word, read after a gap.
        for (int m = 0; m < 16; m++) begin
            cyc(0, 1, 1, 4'hF, 0, 36'h0);
            cyc(0, 0, 0, 4'(m), 5, 36'h0);
            cyc(0, 1, 1, 4'hF, 0, pat(5, 100 + m));
            cyc(0, 0, 1, 4'hF, 5, 36'h0, (m == 15) ? "R3" : "R2");
        end

        // R7: read in the data cycle of a write to the same address.
        for (int m = 0; m < 16; m++) begin
            cyc(0, 1, 1, 4'hF, 0, 36'h0);
            cyc(0, 0, 0, 4'(m), 9, 36'h0);
            cyc(0, 0, 1, 4'h0, 9, pat(9, 200 + m));
        end
        // R1: read of another address in the data cycle takes no bypass.
        cyc(0, 1, 1, 4'hF, 0, 36'h0);
        cyc(0, 0, 0, 4'h0, 10, 36'h0);
        cyc(0, 0, 1, 4'h0, 11, pat(10, 300));
        cyc(0, 0, 1, 4'h0, 10, 36'h0);

        // R4: deselect with write strobe low leaves memory alone.
        cyc(0, 1, 0, 4'h0, 3, 36'h0);
        cyc(0, 1, 1, 4'h0, 3, pat(3, 400));
        cyc(0, 0, 1, 4'hF, 3, 36'h0, "R4");

        // R5: sleep in the data cycle drops the write; read under sleep ignored.
        cyc(0, 0, 0, 4'h0, 4, 36'h0);
        cyc(1, 0, 1, 4'h0, 4, pat(4, 500));
        cyc(1, 0, 1, 4'h0, 4, 36'h0);
        cyc(0, 0, 1, 4'hF, 4, 36'h0, "R5");
        sleep_i = 1'b1;
        #1;
        check("R5 doe gated at once", 36'(doe), 36'(0));
        cyc(1, 0, 0, 4'h0, 6, 36'h0);
        cyc(0, 1, 1, 4'hF, 0, pat(6, 600));
        cyc(0, 0, 1, 4'hF, 6, 36'h0, "R5");

        // R8: turnaround cases.
        cyc(0, 0, 1, 4'hF, 1, 36'h0);
        cyc(0, 0, 0, 4'h0, 2, 36'h0);
        cyc(0, 0, 1, 4'hF, 1, pat(2, 700));
        cyc(0, 0, 0, 4'hF, 2, 36'h0);
        cyc(0, 0, 1, 4'hF, 2, 36'h0);
        cyc(0, 1, 1, 4'hF, 0, 36'h0);
        cyc(0, 0, 0, 4'h6, 2, 36'h0);
        cyc(0, 1, 1, 4'hF, 0, pat(2, 800));
        cyc(0, 0, 1, 4'hF, 2, 36'h0);
        cyc(0, 1, 1, 4'hF, 0, 36'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule